// File: doc/BRIEF.md
# Shared Message Queue Pointer Pair with Two-Sided Reset

This block holds the write-side (put) and read-side (get) indices of a circular message ring that two processors share. The producer advances the put index for each message it deposits, and the consumer advances the get index for each message it takes. Both indices wrap to zero after a programmable last index. The block reports empty and full from the two indices. The entry storage, bus decode and interrupts sit outside the block.

A 32-bit control word holds the last-index value and two handshake flags. The local side can only set its flag. The remote side can only set its request flag, through a separate strobe. Neither flag on its own disturbs the indices. Once both flags are set, the indices and both flags return to zero together on the next clock edge.

Top module: `msg_queue_ptrs`

## Requirements
- R1: After reset, put and get indices are 0, the control word reads 0, empty_o is 1 and both error pulses are 0.
- R2: Writing the control word stores bits [15:0] as the last index, which reads back the cycle after the write. A size of S gives S+1 slots. Writing a new size never moves either index.
- R3: A write with bit 31 set sets the local flag, which reads back at bit 31. A write with bit 31 clear leaves the flag as it was. Bit 30 of a write has no effect.
- R4: A one-cycle remote_req_i strobe sets the request flag, which reads back at bit 30.
- R5: While only one of the two flags is set, no index moves except by put or get requests.
- R6: In the cycle after a clock edge that sees both flags set, both indices read 0 and both flags read 0. That reset takes priority over a put or get request presented in the same cycle.
- R7: Bits [29:16] of the control word always read 0, whatever was written there.
- R8: An accepted request moves its index up by 1. An index at or beyond the last index moves to 0 instead.
- R9: empty_o is 1 exactly when the indices are equal. full_o is 1 exactly when the wrapped successor of put equals get, so a ring of S+1 slots holds at most S messages.
- R10: A put request while full leaves the put index unchanged, and put_err_o goes high for exactly the following cycle.
- R11: A get request while empty leaves the get index unchanged, and get_err_o goes high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Local control-word write strobe |
| cfg_wdata_i | input | 32 | Local control-word write data |
| cfg_rdata_o | output | 32 | Control word: local flag [31], request flag [30], zero [29:16], last index [15:0] |
| remote_req_i | input | 1 | Remote side sets the request flag |
| put_i | input | 1 | Enqueue request (advance put index) |
| get_i | input | 1 | Dequeue request (advance get index) |
| put_ptr_o | output | 16 | Current put index |
| get_ptr_o | output | 16 | Current get index |
| empty_o | output | 1 | Ring empty |
| full_o | output | 1 | Ring full |
| put_err_o | output | 1 | One-cycle pulse: put refused because the ring was full |
| get_err_o | output | 1 | One-cycle pulse: get refused because the ring was empty |

## Verification
The hardest case to reach is the reset taking effect in the same cycle as a put or get. It needs both flags to be set when the edge arrives, which takes a write and a remote strobe in earlier cycles. The stimulus first sets one flag, idles to show the indices hold, then sets the second flag. It then presents a put and a get together in the very cycle the pair is complete. A second pass sets the flags in the reverse order. A last-index value of 0 is also driven, which makes the ring empty and full at once, so every request is refused.

// File: rtl/qp_pkg.sv
`timescale 1ns/1ps
package qp_pkg;
  localparam int unsigned CW_W    = 32;
  localparam int unsigned LOC_BIT = 31;
  localparam int unsigned REM_BIT = 30;

  typedef struct packed {
    logic loc;
    logic rem;
  } hs_flags_t;
endpackage

// File: rtl/qp_ptr.sv
`timescale 1ns/1ps
module qp_ptr #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic [IDX_W-1:0] nxt_o
);
  logic [IDX_W-1:0] ptr_q;

  // at or past last index wraps, covers a size shrunk under a live pointer
  assign nxt_o = (ptr_q >= last_i) ? '0 : ptr_q + 1'b1;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (adv_i) ptr_q <= nxt_o;
  end
endmodule

// File: rtl/qp_ctrl.sv
`timescale 1ns/1ps
module qp_ctrl
  import qp_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CW_W-1:0]  wdata_i,
  input  logic             remote_req_i,
  output logic [IDX_W-1:0] last_o,
  output logic             clr_o,
  output logic [CW_W-1:0]  rdata_o
);
  localparam int unsigned RSV_W = REM_BIT - IDX_W;

  hs_flags_t        flg_q;
  logic [IDX_W-1:0] last_q;

  assign clr_o  = flg_q.loc & flg_q.rem;
  assign last_o = last_q;
  assign rdata_o = {flg_q.loc, flg_q.rem, {RSV_W{1'b0}}, last_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_q <= '0;
    else if (we_i) last_q <= wdata_i[IDX_W-1:0];
  end

  // set-only flags; the joint reset clears both and beats a new set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
    end else if (clr_o) begin
      flg_q <= '0;
    end else begin
      if (we_i && wdata_i[LOC_BIT]) flg_q.loc <= 1'b1;
      if (remote_req_i)             flg_q.rem <= 1'b1;
    end
  end
endmodule

// File: rtl/msg_queue_ptrs.sv
`timescale 1ns/1ps
module msg_queue_ptrs
  import qp_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CW_W-1:0]  cfg_wdata_i,
  output logic [CW_W-1:0]  cfg_rdata_o,
  input  logic             remote_req_i,
  input  logic             put_i,
  input  logic             get_i,
  output logic [IDX_W-1:0] put_ptr_o,
  output logic [IDX_W-1:0] get_ptr_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             put_err_o,
  output logic             get_err_o
);
  logic [IDX_W-1:0] last;
  logic             clr;
  logic [IDX_W-1:0] put_nxt, get_nxt;
  logic             put_ok, get_ok;
  logic             perr_q, gerr_q;

  qp_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .wdata_i      (cfg_wdata_i),
    .remote_req_i (remote_req_i),
    .last_o       (last),
    .clr_o        (clr),
    .rdata_o      (cfg_rdata_o)
  );

  qp_ptr #(.IDX_W(IDX_W)) i_put (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (put_ok),
    .last_i (last),
    .ptr_o  (put_ptr_o),
    .nxt_o  (put_nxt)
  );

  qp_ptr #(.IDX_W(IDX_W)) i_get (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (get_ok),
    .last_i (last),
    .ptr_o  (get_ptr_o),
    .nxt_o  (get_nxt)
  );

  assign empty_o = (put_ptr_o == get_ptr_o);
  assign full_o  = (put_nxt == get_ptr_o);
  assign put_ok  = put_i & ~full_o;
  assign get_ok  = get_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_q <= 1'b0;
      gerr_q <= 1'b0;
    end else begin
      perr_q <= put_i & full_o;
      gerr_q <= get_i & empty_o;
    end
  end

  assign put_err_o = perr_q;
  assign get_err_o = gerr_q;
endmodule

// File: rtl/qp_chk.sv
`timescale 1ns/1ps
module qp_chk #(
  parameter int unsigned IDX_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [31:0]      cfg_wdata_i,
  input logic [31:0]      cfg_rdata_o,
  input logic             remote_req_i,
  input logic             put_i,
  input logic             get_i,
  input logic [IDX_W-1:0] put_ptr_o,
  input logic [IDX_W-1:0] get_ptr_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             put_err_o,
  input logic             get_err_o
);
  logic both;
  assign both = cfg_rdata_o[31] & cfg_rdata_o[30];

  a_r6_joint_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both |=> (put_ptr_o == '0) && (get_ptr_o == '0) && !cfg_rdata_o[31] && !cfg_rdata_o[30]);

  a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both && !put_i && !get_i) |=> $stable(put_ptr_o) && $stable(get_ptr_o));

  a_r3_local_set_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[31] && !(cfg_we_i && cfg_wdata_i[31])) |=> !cfg_rdata_o[31]);

  a_r4_remote_set_by_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[30] && !remote_req_i) |=> !cfg_rdata_o[30]);

  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[29:IDX_W] == '0);

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (put_i && full_o && !both) |=> $stable(put_ptr_o) && put_err_o);

  a_r11_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (get_i && empty_o && !both) |=> $stable(get_ptr_o) && get_err_o);

  a_r9_empty_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (put_ptr_o == get_ptr_o));
endmodule

bind msg_queue_ptrs qp_chk #(.IDX_W(IDX_W)) i_qp_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .remote_req_i (remote_req_i),
  .put_i        (put_i),
  .get_i        (get_i),
  .put_ptr_o    (put_ptr_o),
  .get_ptr_o    (get_ptr_o),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .put_err_o    (put_err_o),
  .get_err_o    (get_err_o)
);

// File: tb/test_msg_queue_ptrs.sv
`timescale 1ns/1ps
module test_msg_queue_ptrs;
  localparam int W = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [31:0]   cfg_wdata_i = '0;
  logic [31:0]   cfg_rdata_o;
  logic          remote_req_i = 1'b0;
  logic          put_i = 1'b0;
  logic          get_i = 1'b0;
  logic [W-1:0]  put_ptr_o, get_ptr_o;
  logic          empty_o, full_o, put_err_o, get_err_o;

  always #4 clk_i = ~clk_i;

  msg_queue_ptrs #(.IDX_W(W)) i_msg_queue_ptrs (.*);

  typedef struct {
    logic [W-1:0] put;
    logic [W-1:0] get;
    logic         emp;
    logic         ful;
    logic         perr;
    logic         gerr;
    logic [31:0]  rd;
    string        tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [W-1:0] m_put = '0, m_get = '0, m_last = '0;
  logic         m_loc = 0, m_rem = 0;

  function automatic logic [W-1:0] wrap(logic [W-1:0] p, logic [W-1:0] l);
    return (p >= l) ? '0 : p + 1'b1;
  endfunction

  task automatic step(bit pu, bit ge, bit we, logic [31:0] wd, bit rm, string tag);
    exp_t e;
    bit clr, ful, emp, pe, gerr;
    @(negedge clk_i);
    put_i = pu; get_i = ge; cfg_we_i = we; cfg_wdata_i = wd; remote_req_i = rm;
    clr  = m_loc && m_rem;
    ful  = (wrap(m_put, m_last) == m_get);
    emp  = (m_put == m_get);
    pe   = pu && ful;
    gerr = ge && emp;
    if (clr) begin
      m_put = '0; m_get = '0; m_loc = 0; m_rem = 0;
    end else begin
      if (pu && !ful) m_put = wrap(m_put, m_last);
      if (ge && !emp) m_get = wrap(m_get, m_last);
      if (we && wd[31]) m_loc = 1;
      if (rm) m_rem = 1;
    end
    if (we) m_last = wd[W-1:0];
    e.put = m_put; e.get = m_get;
    e.emp = (m_put == m_get);
    e.ful = (wrap(m_put, m_last) == m_get);
    e.perr = pe; e.gerr = gerr;
    e.rd = {m_loc, m_rem, 14'd0, m_last};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 32'h0, 0, tag);
  endtask

  // monitor: compares 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (put_ptr_o !== e.put || get_ptr_o !== e.get || empty_o !== e.emp ||
            full_o !== e.ful || put_err_o !== e.perr || get_err_o !== e.gerr ||
            cfg_rdata_o !== e.rd) begin
          bad++;
          $display("FAIL %s: act put=%0d get=%0d e=%b f=%b pe=%b ge=%b rd=%h exp put=%0d get=%0d e=%b f=%b pe=%b ge=%b rd=%h",
                   e.tag, put_ptr_o, get_ptr_o, empty_o, full_o, put_err_o, get_err_o,
                   cfg_rdata_o, e.put, e.get, e.emp, e.ful, e.perr, e.gerr, e.rd);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #10;
    total++;
    if (put_ptr_o !== 0 || get_ptr_o !== 0 || cfg_rdata_o !== 0 || empty_o !== 1 ||
        put_err_o !== 0 || get_err_o !== 0) begin
      bad++;
      $display("FAIL R1 reset: act put=%0d get=%0d rd=%h e=%b exp 0 0 0 1",
               put_ptr_o, get_ptr_o, cfg_rdata_o, empty_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    step(0, 0, 1, 32'h0000_0003, 0, "R2 size write");
    idle("R1 idle after size");
    step(1, 0, 0, 0, 0, "R8 put 1");
    step(1, 0, 0, 0, 0, "R8 put 2");
    step(1, 0, 0, 0, 0, "R9 put 3 full");
    step(1, 0, 0, 0, 0, "R10 put while full");
    idle("R10 err one cycle");
    step(0, 1, 0, 0, 0, "R8 get 1");
    step(1, 1, 0, 0, 0, "R8 put wrap and get");
    step(0, 1, 0, 0, 0, "R8 get 3");
    step(0, 1, 0, 0, 0, "R9 get empty");
    step(0, 1, 0, 0, 0, "R11 get while empty");
    idle("R11 err one cycle");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, "R8 stream wrap");
    step(0, 0, 1, 32'h7FFF_0003, 0, "R3 bit30 write ignored R7 reserved");
    step(0, 0, 1, 32'h0000_0003, 0, "R3 write zero keeps");
    step(1, 0, 0, 0, 0, "R8 put prep");
    step(1, 0, 0, 0, 0, "R8 put prep 2");
    step(0, 0, 1, 32'h8000_0003, 0, "R3 local set");
    idle("R5 local only hold");
    step(0, 0, 1, 32'h0000_0003, 0, "R3 write 0 no clear");
    idle("R5 local only hold 2");
    step(0, 0, 0, 0, 1, "R4 remote set");
    step(1, 1, 0, 0, 0, "R6 reset beats put get");
    idle("R6 after reset");
    step(1, 0, 0, 0, 0, "R8 put after reset");
    step(1, 0, 0, 0, 0, "R8 put after reset 2");
    step(0, 0, 0, 0, 1, "R4 remote first");
    idle("R5 remote only hold");
    step(0, 1, 0, 0, 0, "R5 get while remote only");
    step(0, 0, 1, 32'h8000_0003, 0, "R3 local second");
    idle("R6 reverse order reset");
    step(1, 1, 0, 0, 0, "R9 empty after reset");
    step(1, 0, 0, 0, 0, "R8 put");
    step(1, 0, 0, 0, 0, "R8 put to 3");
    step(0, 0, 1, 32'h0000_0007, 0, "R2 size change keeps pointers");
    step(1, 0, 0, 0, 0, "R8 put to 4 under new size");
    step(0, 0, 1, 32'h0000_0002, 0, "R2 shrink size");
    step(1, 0, 0, 0, 0, "R8 past last wraps");
    step(0, 0, 1, 32'h8000_0000, 1, "R6 set both, size zero");
    idle("R6 clear with size zero");
    step(1, 0, 0, 0, 0, "R10 size zero put refused");
    step(0, 1, 0, 0, 0, "R11 size zero get refused");
    idle("R11 final");
    idle("R1 drain");

    @(negedge clk_i);
    #4;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule